// File: doc/BRIEF.md
# Level-Tracked Interrupt Aggregator

This block merges a vector of level-sensitive interrupt lines into a single interrupt request for a processor. Each line owns one bit of a status word. The bit follows the line: a line that goes high sets its bit, and a line that goes low clears it again. An enable word masks the status word. The request output is high whenever any bit is both pending and enabled.

Software reaches the block through a small synchronous register port with an address, a write strobe with write data, and a read strobe with read data. Four word slots are decoded. The raw slot returns the status word, and a write to it clears every bit written as one. The load slot replaces the whole status word with the written value, and a read of it returns the status word. The mask slot holds the enable word. The view slot returns status AND enable and ignores writes. Any register write takes effect on the request output at the same clock edge that updates the register.

Top module: `irq_agg_top`

## Requirements
- R1: After reset the status word and the enable word are zero, irq_req is low, and bus_rdata is zero.
- R2: When line i goes from low to high, status bit i is 1 after the next clock edge.
- R3: When line i goes from high to low, status bit i is 0 after the next clock edge.
- R4: irq_req is registered. It equals the OR-reduction of (status AND enable) as those registers stand after the same edge.
- R5: A write to offset 0x0 clears each status bit whose write-data bit is 1. Bits written as 0 keep their value.
- R6: A write to offset 0x4 replaces all status bits with the write data.
- R7: A write to offset 0x8 replaces the enable word. irq_req reflects the new mask at that same edge.
- R8: A read of offset 0xC returns status AND enable. A write to offset 0xC changes neither the status word nor the enable word.
- R9: A read of offset 0x4 returns the raw status word, the same value as a read of offset 0x0.
- R10: Offsets other than 0x0, 0x4, 0x8 and 0xC, including any offset with bits [1:0] nonzero, read as zero. Writes to them change no register.
- R11: When a line changes level in the same cycle as a status write that touches its bit, the bit takes the new line level.
- R12: bus_rdata is registered. One edge after bus_rd is sampled high, it shows the addressed register as it stood before that edge. It is zero after any edge at which bus_rd was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte offset of the register slot |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, sampled at the rising edge |
| bus_rdata | output | 32 | Registered read data |
| irq_lines | input | 32 | Level interrupt inputs, bit i is line i |
| irq_req | output | 1 | Registered interrupt request |

## Verification
Every result is due one edge after its cause. A line change or register write sampled at an edge shows in the status word, and in irq_req, right after that edge. Read data appears after the edge that samples bus_rd and reflects the registers as they stood before that edge. The bench applies stimulus at the falling edge and samples 1 ns after the following rising edge. It keeps a shadow model of status, enable and the previous line levels, which it advances once per edge. Each read and each irq_req value is checked against the model state from the matching side of that edge. Directed steps cover the same-cycle collision between a line and a write, unmapped and misaligned offsets, and the ignored view-slot write. A seeded random phase then mixes all of these.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  // Word slot selected by bus_addr[3:2]
  typedef enum logic [1:0] {
    SLOT_RAW  = 2'd0,
    SLOT_LOAD = 2'd1,
    SLOT_MASK = 2'd2,
    SLOT_VIEW = 2'd3
  } slot_e;

  typedef struct packed {
    logic clr;
    logic load;
    logic mask;
  } wr_strobe_t;

endpackage

// File: rtl/irq_agg_regdec.sv
module irq_agg_regdec
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output wr_strobe_t        wstb,
  output logic              rd_hit,
  output slot_e             rd_slot
);

  logic upper_zero;
  logic hit;
  slot_e slot;

  generate
    if (ADDR_W > 4) begin : g_wide
      assign upper_zero = (addr[ADDR_W-1:4] == '0);
    end else begin : g_narrow
      assign upper_zero = 1'b1;
    end
  endgenerate

  assign hit  = upper_zero && (addr[1:0] == 2'b00);
  assign slot = slot_e'(addr[3:2]);

  always_comb begin
    wstb.clr  = wr && hit && (slot == SLOT_RAW);
    wstb.load = wr && hit && (slot == SLOT_LOAD);
    wstb.mask = wr && hit && (slot == SLOT_MASK);
  end

  assign rd_hit  = rd && hit;
  assign rd_slot = slot;

endmodule

// File: rtl/irq_agg_status.sv
module irq_agg_status #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lines,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] status_q,
  output logic [W-1:0] status_nx,
  output logic [W-1:0] chg
);

  logic [W-1:0] prev_q;

  // Apply a software write, then let changed lines override their bits
  function automatic logic [W-1:0] next_status(
    input logic [W-1:0] cur,
    input logic         c,
    input logic         l,
    input logic [W-1:0] d,
    input logic [W-1:0] lv,
    input logic [W-1:0] ch
  );
    logic [W-1:0] v;
    v = cur;
    if (c) v = v & ~d;
    if (l) v = d;
    return (v & ~ch) | (lv & ch);
  endfunction

  assign chg       = lines ^ prev_q;
  assign status_nx = next_status(status_q, clr, load, wdata, lines, chg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= lines;
      status_q <= status_nx;
    end
  end

endmodule

// File: rtl/irq_agg_outgen.sv
module irq_agg_outgen #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] status_q,
  input  logic [W-1:0] status_nx,
  output logic [W-1:0] enable_q,
  output logic [W-1:0] masked,
  output logic         irq_req
);

  logic [W-1:0] enable_nx;

  function automatic logic any_pending(input logic [W-1:0] s, input logic [W-1:0] e);
    return |(s & e);
  endfunction

  assign enable_nx = en_wr ? wdata : enable_q;
  assign masked    = status_q & enable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      irq_req  <= 1'b0;
    end else begin
      enable_q <= enable_nx;
      irq_req  <= any_pending(status_nx, enable_nx);
    end
  end

endmodule

// File: rtl/irq_agg_rdmux.sv
module irq_agg_rdmux
  import irq_agg_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_hit,
  input  slot_e        rd_slot,
  input  logic [W-1:0] status_q,
  input  logic [W-1:0] enable_q,
  input  logic [W-1:0] masked,
  output logic [W-1:0] rdata_q
);

  logic [W-1:0] sel;

  always_comb begin
    unique case (rd_slot)
      SLOT_RAW:  sel = status_q;
      SLOT_LOAD: sel = status_q;
      SLOT_MASK: sel = enable_q;
      SLOT_VIEW: sel = masked;
      default:   sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rd_hit ? sel : '0;
  end

endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [W-1:0]      bus_wdata,
  input  logic              bus_rd,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      irq_lines,
  output logic              irq_req
);

  wr_strobe_t   wstb;
  logic         rd_hit;
  slot_e        rd_slot;
  logic         wr_clr;
  logic         wr_load;
  logic         wr_mask;
  logic [W-1:0] status_q;
  logic [W-1:0] status_nx;
  logic [W-1:0] chg;
  logic [W-1:0] enable_q;
  logic [W-1:0] masked;

  irq_agg_regdec #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (bus_addr),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .wstb    (wstb),
    .rd_hit  (rd_hit),
    .rd_slot (rd_slot)
  );

  assign wr_clr  = wstb.clr;
  assign wr_load = wstb.load;
  assign wr_mask = wstb.mask;

  irq_agg_status #(.W(W)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .lines     (irq_lines),
    .clr       (wr_clr),
    .load      (wr_load),
    .wdata     (bus_wdata),
    .status_q  (status_q),
    .status_nx (status_nx),
    .chg       (chg)
  );

  irq_agg_outgen #(.W(W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_wr     (wr_mask),
    .wdata     (bus_wdata),
    .status_q  (status_q),
    .status_nx (status_nx),
    .enable_q  (enable_q),
    .masked    (masked),
    .irq_req   (irq_req)
  );

  irq_agg_rdmux #(.W(W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_hit   (rd_hit),
    .rd_slot  (rd_slot),
    .status_q (status_q),
    .enable_q (enable_q),
    .masked   (masked),
    .rdata_q  (bus_rdata)
  );

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int W      = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      irq_lines,
  input logic              irq_req,
  input logic              wr_clr,
  input logic              wr_load,
  input logic              wr_mask,
  input logic [W-1:0]      status_q,
  input logic [W-1:0]      enable_q,
  input logic [W-1:0]      chg
);

  logic any_strobe;
  assign any_strobe = wr_clr | wr_load | wr_mask;

  // R4
  req_matches_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == |(status_q & enable_q));

  // R11
  line_change_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((status_q ^ $past(irq_lines)) & $past(chg)) == '0));

  // R5
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && chg == '0) |=> ((status_q & $past(bus_wdata)) == '0));

  // R6
  load_replaces_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_load && chg == '0) |=> (status_q == $past(bus_wdata)));

  // R8
  view_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'hC) |=> $stable(enable_q));

  // R10
  unmapped_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[1:0] != 2'b00) |-> !any_strobe);

  // R7
  mask_write_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (enable_q == $past(bus_wdata)));

endmodule

bind irq_agg_top irq_agg_chk #(.W(W), .ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .irq_lines (irq_lines),
  .irq_req   (irq_req),
  .wr_clr    (wr_clr),
  .wr_load   (wr_load),
  .wr_mask   (wr_mask),
  .status_q  (status_q),
  .enable_q  (enable_q),
  .chg       (chg)
);

// File: tb/test_irq_agg_top.sv
`timescale 1ns/1ps
module test_irq_agg_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_lines = '0;
  logic        irq_req;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // shadow model
  logic [31:0] m_st = '0;
  logic [31:0] m_en = '0;
  logic [31:0] m_prev = '0;

  always #2 clk = ~clk;

  irq_agg_top i_irq_agg_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .irq_lines(irq_lines), .irq_req(irq_req)
  );

  function automatic logic [31:0] exp_read(input logic [3:0] a, input logic [31:0] st, input logic [31:0] en);
    case (a)
      4'h0, 4'h4: return st;
      4'h8:       return en;
      4'hC:       return st & en;
      default:    return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_status(input logic [31:0] st, input logic [3:0] a, input logic wr,
                                             input logic [31:0] d, input logic [31:0] ln, input logic [31:0] pv);
    logic [31:0] r;
    logic [31:0] moved;
    r = st;
    if (wr && a == 4'h0) r = st & ~d;
    if (wr && a == 4'h4) r = d;
    moved = ln ^ pv;
    for (int i = 0; i < 32; i++) if (moved[i]) r[i] = ln[i];
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus cycle; checks irq_req always and read data
  task automatic step(input logic [3:0] a, input logic wr, input logic [31:0] d,
                      input logic rd, input logic [31:0] ln, input string tag);
    logic [31:0] er;
    @(negedge clk);
    bus_addr = a; bus_wr = wr; bus_wdata = d; bus_rd = rd; irq_lines = ln;
    er = rd ? exp_read(a, m_st, m_en) : 32'h0;
    m_st = exp_status(m_st, a, wr, d, ln, m_prev);
    if (wr && a == 4'h8) m_en = d;
    m_prev = ln;
    @(posedge clk); #1;
    check({tag, " irq R4"}, {31'h0, irq_req}, {31'h0, |(m_st & m_en)});
    check({tag, " rdata R12"}, bus_rdata, er);
  endtask

  task automatic rd_reg(input logic [3:0] a, input string tag);
    step(a, 1'b0, 32'h0, 1'b1, irq_lines, tag);
  endtask

  initial begin : watchdog
    #400000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1;
    check("R1 irq after reset", {31'h0, irq_req}, 32'h0);
    check("R1 rdata after reset", bus_rdata, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    rd_reg(4'h0, "R1 status zero");
    rd_reg(4'h8, "R1 enable zero");

    step(4'h8, 1, 32'hFFFF_FFFF, 0, 32'h0, "R7 enable all");
    rd_reg(4'h8, "R7 enable readback");
    step(4'h0, 0, 0, 0, 32'h0000_0008, "R2 line3 rise");
    check("R2 irq on rise", {31'h0, irq_req}, 32'h1);
    rd_reg(4'h0, "R2 status bit3");
    step(4'h0, 1, 32'h0000_0008, 0, 32'h0000_0008, "R5 w1c bit3");
    rd_reg(4'h0, "R5 status after w1c");
    check("R5 irq low after w1c", {31'h0, irq_req}, 32'h0);
    step(4'h0, 0, 0, 0, 32'h0000_0028, "R2 line5 rise");
    step(4'h0, 0, 0, 0, 32'h0000_0008, "R3 line5 fall");
    rd_reg(4'h0, "R3 status after fall");
    check("R3 bit5 clear", bus_rdata & 32'h20, 32'h0);

    step(4'h4, 1, 32'hA5A5_0000, 0, 32'h0000_0008, "R6 load");
    rd_reg(4'h0, "R6 status loaded");
    check("R6 loaded value", bus_rdata, 32'hA5A5_0000);
    rd_reg(4'h4, "R9 read load slot");
    check("R9 load slot value", bus_rdata, 32'hA5A5_0000);

    step(4'h8, 1, 32'hFF00_0000, 0, 32'h0000_0008, "R7 enable high byte");
    rd_reg(4'hC, "R8 masked view");
    check("R8 masked value", bus_rdata, 32'hA500_0000);
    step(4'hC, 1, 32'h0000_0000, 0, 32'h0000_0008, "R8 view write");
    rd_reg(4'h8, "R8 enable unchanged");
    rd_reg(4'hC, "R8 view unchanged");

    step(4'h8, 1, 32'h0, 0, 32'h0000_0008, "R7 mask off");
    check("R7 irq drops same edge", {31'h0, irq_req}, 32'h0);
    step(4'h8, 1, 32'h0000_0100, 0, 32'h0000_0008, "R7 mask on idle bit");
    check("R7 irq stays low", {31'h0, irq_req}, 32'h0);

    rd_reg(4'h1, "R10 misaligned read");
    rd_reg(4'h6, "R10 misaligned read2");
    step(4'h2, 1, 32'hFFFF_FFFF, 0, 32'h0000_0008, "R10 write unmapped");
    step(4'h9, 1, 32'hFFFF_FFFF, 0, 32'h0000_0008, "R10 write unmapped2");
    rd_reg(4'h0, "R10 status unchanged");
    rd_reg(4'h8, "R10 enable unchanged");

    step(4'h0, 1, 32'h0000_0080, 0, 32'h0000_0088, "R11 rise vs w1c");
    rd_reg(4'h0, "R11 bit7 set");
    check("R11 bit7 kept", bus_rdata & 32'h80, 32'h80);
    step(4'h0, 0, 0, 0, 32'h0000_0288, "R11 line9 up");
    step(4'h4, 1, 32'hFFFF_FFFF, 0, 32'h0000_0088, "R11 fall vs load");
    rd_reg(4'h0, "R11 bit9 cleared");
    check("R11 bit9 value", bus_rdata & 32'h200, 32'h0);

    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      logic [3:0]  a;
      logic [31:0] ln;
      logic [31:0] d;
      logic        wr;
      logic        rd;
      int          pick;
      pick = $urandom_range(0, 9);
      a  = (pick < 8) ? 4'(($urandom_range(0, 3)) * 4) : 4'($urandom_range(0, 15));
      wr = ($urandom_range(0, 2) == 0);
      rd = ($urandom_range(0, 1) == 0);
      d  = $urandom();
      if ($urandom_range(0, 1) == 0) d = d & 32'h0000_00FF;
      ln = irq_lines;
      if ($urandom_range(0, 3) == 0) ln = ln ^ (32'h1 << $urandom_range(0, 31));
      step(a, wr, d, rd, ln, "R12 random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule